// File: doc/BRIEF.md
# I2C Acknowledge Polling Sequencer

Some I2C slaves, nonvolatile memories among them, run an internal write cycle after a transfer and cannot stretch the clock while they do. During that cycle they ignore their own address. This sequencer drives a byte-level I2C master so that the master keeps probing such a slave until it answers. Each probe is a START condition followed by the address byte with the direction bit cleared. A NACK means the slave is still busy: the sequencer closes the transaction with STOP, waits a fixed number of cycles and probes again. An ACK means the slave is ready. The sequencer then reports ready and either releases the bus with STOP or keeps it open, so that the caller can continue in the same transaction.

A caller pulses `start` with the slave address and the keep-bus choice. It then waits for a one-cycle `ready` pulse, or for a one-cycle `timeout` pulse if the slave never answered within the retry limit. The master side is a simple command port. The sequencer holds `cmdValid`, `cmdOp` and `cmdByte` steady until the master pulses `cmdDone`. For an address write, the master also returns the acknowledge bit it sampled on `cmdAck`.

Top module: `ackPollSeq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `ready`, `timeout`, `busy` and `cmdValid` are low.
- R2: Every poll attempt issues a START command (`cmdOp` = 1) and then a WRITE command (`cmdOp` = 2) whose `cmdByte` holds the captured address in bits 7..1 and 0 in bit 0.
- R3: After a NACK on the address byte that is not the last allowed, the sequencer issues a STOP command (`cmdOp` = 3). It then spends exactly GAP_CYCLES cycles busy with `cmdValid` low, and then issues the next START.
- R4: After an ACK with keep-bus cleared, the sequencer issues one STOP command and then pulses `ready`.
- R5: After an ACK with keep-bus set, the sequencer pulses `ready` without issuing a STOP.
- R6: After MAX_TRIES consecutive NACKs, the sequencer issues STOP, pulses `timeout` instead of `ready`, and returns to idle with `busy` low.
- R7: `ready` and `timeout` are each high for exactly one cycle per poll request, and they are never high together.
- R8: A `start` pulse while `busy` is high has no effect. The address and keep-bus choice of the running poll stay in force, and no extra poll follows.
- R9: Once `cmdValid` rises, `cmdValid` and `cmdOp` hold until the cycle in which `cmdDone` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a poll; sampled only when idle |
| keepBus | input | 1 | Leave the bus open after an ACK (captured with `start`) |
| slaveAddr | input | ADDR_W | 7-bit slave address (captured with `start`) |
| cmdDone | input | 1 | Master has finished the current command |
| cmdAck | input | 1 | Acknowledge sampled on the address byte, valid with `cmdDone` |
| cmdValid | output | 1 | A command is presented to the master |
| cmdOp | output | 2 | Command: 1 START, 2 WRITE, 3 STOP |
| cmdByte | output | ADDR_W+1 | Byte to send with WRITE |
| busy | output | 1 | Poll in progress |
| ready | output | 1 | One-cycle pulse: slave acknowledged |
| timeout | output | 1 | One-cycle pulse: retry limit reached |

## Verification
The bench builds the sequencer with MAX_TRIES = 4 and GAP_CYCLES = 3. These small values let a sweep reach every outcome. A behavioural master answers with a NACK for a chosen number of probes from zero to five, so the sweep covers immediate readiness, readiness on each later probe, the last allowed probe, and running past the limit into a timeout. Each case runs with keep-bus set and cleared and with two address patterns. Each case also carries a stray `start` pulse during the poll. The expected counts of START, WRITE and STOP commands, of gap cycles and of pulses are all worked out from the NACK count.

// File: rtl/apPkg.sv
package apPkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_START = 2'd1,
    OP_WRITE = 2'd2,
    OP_STOP  = 2'd3
  } cmdOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch request, clear try count
    logic bumpTry;  // one more NACK seen
    logic clrGap;   // restart gap counter
    logic bumpGap;  // count one gap cycle
  } dpStrobe_t;

endpackage

// File: rtl/apDatapath.sv
module apDatapath
  import apPkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int GAP_CYCLES = 3,
  parameter int MAX_TRIES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqKeep,
  output logic [ADDR_W:0]   cmdByte,
  output logic              keepQ,
  output logic              lastTry,
  output logic              gapDone
);

  localparam int TRY_W = $clog2(MAX_TRIES + 1);
  localparam int GAP_W = $clog2(GAP_CYCLES + 1);

  logic [ADDR_W-1:0] addrQ;
  logic [TRY_W-1:0]  tryQ;
  logic [GAP_W-1:0]  gapQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      keepQ <= 1'b0;
      tryQ  <= '0;
      gapQ  <= '0;
    end else begin
      if (stb.capture) begin
        addrQ <= reqAddr;
        keepQ <= reqKeep;
        tryQ  <= '0;
      end else if (stb.bumpTry) begin
        tryQ <= tryQ + 1'b1;
      end
      if (stb.clrGap) begin
        gapQ <= '0;
      end else if (stb.bumpGap) begin
        gapQ <= gapQ + 1'b1;
      end
    end
  end

  assign cmdByte = {addrQ, 1'b0};
  assign lastTry = (tryQ == TRY_W'(MAX_TRIES - 1));
  assign gapDone = (gapQ == GAP_W'(GAP_CYCLES - 1));

  // R6
  tries_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    tryQ <= TRY_W'(MAX_TRIES));

endmodule

// File: rtl/apControl.sv
module apControl
  import apPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      cmdDone,
  input  logic      cmdAck,
  input  logic      keepQ,
  input  logic      lastTry,
  input  logic      gapDone,
  output dpStrobe_t stb,
  output logic      cmdValid,
  output cmdOp_e    cmdOp,
  output logic      busy,
  output logic      ready,
  output logic      timeout
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_ADDR, ST_STOP, ST_GAP
  } state_e;

  typedef enum logic [1:0] {
    END_OK, END_RETRY, END_FAIL
  } outcome_e;

  state_e   state;
  outcome_e outcome;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      outcome <= END_OK;
      ready   <= 1'b0;
      timeout <= 1'b0;
    end else begin
      ready   <= 1'b0;
      timeout <= 1'b0;
      case (state)
        ST_IDLE:  if (start) state <= ST_START;
        ST_START: if (cmdDone) state <= ST_ADDR;
        ST_ADDR: if (cmdDone) begin
          if (cmdAck) begin
            if (keepQ) begin
              ready <= 1'b1;
              state <= ST_IDLE;
            end else begin
              outcome <= END_OK;
              state   <= ST_STOP;
            end
          end else begin
            outcome <= lastTry ? END_FAIL : END_RETRY;
            state   <= ST_STOP;
          end
        end
        ST_STOP: if (cmdDone) begin
          case (outcome)
            END_OK:    begin ready   <= 1'b1; state <= ST_IDLE; end
            END_FAIL:  begin timeout <= 1'b1; state <= ST_IDLE; end
            default:   state <= ST_GAP;
          endcase
        end
        ST_GAP:  if (gapDone) state <= ST_START;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb.capture = (state == ST_IDLE) && start;
    stb.bumpTry = (state == ST_ADDR) && cmdDone && !cmdAck;
    stb.clrGap  = (state == ST_STOP) && cmdDone;
    stb.bumpGap = (state == ST_GAP);
    cmdValid    = 1'b1;
    case (state)
      ST_START: cmdOp = OP_START;
      ST_ADDR:  cmdOp = OP_WRITE;
      ST_STOP:  cmdOp = OP_STOP;
      default: begin
        cmdOp    = OP_NONE;
        cmdValid = 1'b0;
      end
    endcase
    busy = (state != ST_IDLE);
  end

  // R7
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ready && timeout));
  // R7
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> !ready);
  // R7
  timeout_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    timeout |=> !timeout);
  // R9
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdDone) |=> (cmdValid && $stable(cmdOp)));
  // R3
  gap_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_GAP && gapDone) |=> (cmdValid && cmdOp == OP_START));

endmodule

// File: rtl/ackPollSeq.sv
module ackPollSeq
  import apPkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int GAP_CYCLES = 3,
  parameter int MAX_TRIES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              keepBus,
  input  logic [ADDR_W-1:0] slaveAddr,
  input  logic              cmdDone,
  input  logic              cmdAck,
  output logic              cmdValid,
  output logic [1:0]        cmdOp,
  output logic [ADDR_W:0]   cmdByte,
  output logic              busy,
  output logic              ready,
  output logic              timeout
);

  dpStrobe_t stb;
  cmdOp_e    opE;
  logic      keepQ, lastTry, gapDone;

  apControl u_ctl (
    .clk(clk), .rstN(rstN), .start(start), .cmdDone(cmdDone),
    .cmdAck(cmdAck), .keepQ(keepQ), .lastTry(lastTry), .gapDone(gapDone),
    .stb(stb), .cmdValid(cmdValid), .cmdOp(opE), .busy(busy),
    .ready(ready), .timeout(timeout)
  );

  apDatapath #(
    .ADDR_W(ADDR_W), .GAP_CYCLES(GAP_CYCLES), .MAX_TRIES(MAX_TRIES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqAddr(slaveAddr),
    .reqKeep(keepBus), .cmdByte(cmdByte), .keepQ(keepQ),
    .lastTry(lastTry), .gapDone(gapDone)
  );

  assign cmdOp = opE;

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> $stable(cmdByte));

endmodule

// File: tb/tb_ackPollSeq.sv
module tb_ackPollSeq;

  localparam int ADDR_W = 7;
  localparam int GAP    = 3;
  localparam int TRIES  = 4;
  localparam int LAT    = 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic              keepBus = 1'b0;
  logic [ADDR_W-1:0] slaveAddr = '0;
  logic              cmdDone = 1'b0;
  logic              cmdAck = 1'b0;
  logic              cmdValid;
  logic [1:0]        cmdOp;
  logic [ADDR_W:0]   cmdByte;
  logic              busy, ready, timeout;

  ackPollSeq #(.ADDR_W(ADDR_W), .GAP_CYCLES(GAP), .MAX_TRIES(TRIES)) dut (
    .clk(clk), .rstN(rstN), .start(start), .keepBus(keepBus),
    .slaveAddr(slaveAddr), .cmdDone(cmdDone), .cmdAck(cmdAck),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdByte(cmdByte), .busy(busy),
    .ready(ready), .timeout(timeout)
  );

  always #10 clk = ~clk;

  int vectors = 0;
  int fails = 0;

  // bench-side master model state
  int                busyN = 0;
  logic [ADDR_W-1:0] expAddr = '0;
  int nStart = 0, nWrite = 0, nStop = 0, nReady = 0, nTo = 0, nGap = 0;
  int byteErr = 0, orderErr = 0, holdErr = 0, writeBase = 0;

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // responder and monitor, all at the falling edge
  initial begin
    int waitCnt = 0;
    logic [1:0] heldOp = 2'd0;
    logic [1:0] prevOp = 2'd0;
    forever begin
      @(negedge clk);
      if (ready) nReady++;
      if (timeout) nTo++;
      if (busy && !cmdValid) nGap++;
      if (cmdDone) begin
        cmdDone = 1'b0;
        cmdAck  = 1'b0;
        waitCnt = 0;
      end else if (cmdValid) begin
        if (waitCnt == 0) heldOp = cmdOp;
        else if (cmdOp != heldOp) holdErr++;
        waitCnt++;
        if (waitCnt == LAT) begin
          cmdDone = 1'b1;
          case (cmdOp)
            2'd1: nStart++;
            2'd2: begin
              nWrite++;
              if (prevOp != 2'd1) orderErr++;
              if (cmdByte != {expAddr, 1'b0}) byteErr++;
              cmdAck = ((nWrite - writeBase) > busyN);
            end
            2'd3: nStop++;
            default: holdErr++;
          endcase
          prevOp = cmdOp;
        end
      end
    end
  end

  task automatic runPoll(input int n, input logic keep, input logic [ADDR_W-1:0] a);
    int s0, w0, p0, r0, t0, g0, b0, o0, h0;
    int attempts, expStops, guard;
    busyN = n; expAddr = a;
    s0 = nStart; w0 = nWrite; p0 = nStop; r0 = nReady; t0 = nTo;
    g0 = nGap; b0 = byteErr; o0 = orderErr; h0 = holdErr;
    writeBase = nWrite;
    @(negedge clk);
    slaveAddr = a; keepBus = keep; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    // stray request during the poll: must be ignored (R8)
    slaveAddr = a ^ 7'h55; keepBus = ~keep; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    guard = 0;
    while ((nReady == r0) && (nTo == t0) && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
    chk("watchdog", int'(guard >= 3000), 0);
    repeat (30) @(negedge clk);
    attempts = (n < TRIES) ? n + 1 : TRIES;
    expStops = (n < TRIES) ? (keep ? n : n + 1) : TRIES;
    chk("R2 START count", nStart - s0, attempts);
    chk("R2 WRITE count", nWrite - w0, attempts);
    chk("R2/R8 address byte errors", byteErr - b0, 0);
    chk("R2 START before WRITE", orderErr - o0, 0);
    chk("R3 gap cycles", nGap - g0, (attempts - 1) * GAP);
    if (n >= TRIES) chk("R6 STOP count", nStop - p0, expStops);
    else if (keep) chk("R5 STOP count", nStop - p0, expStops);
    else chk("R4 STOP count", nStop - p0, expStops);
    chk("R7 ready cycles", nReady - r0, (n < TRIES) ? 1 : 0);
    chk("R6 timeout cycles", nTo - t0, (n >= TRIES) ? 1 : 0);
    chk("R9 command hold errors", holdErr - h0, 0);
    chk("R6/R8 idle after end", int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", int'(ready), 0);
    chk("R1 timeout in reset", int'(timeout), 0);
    chk("R1 busy in reset", int'(busy), 0);
    chk("R1 cmdValid in reset", int'(cmdValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 cmdValid after reset", int'(cmdValid), 0);
    for (int n = 0; n <= TRIES + 1; n++)
      for (int k = 0; k < 2; k++)
        for (int ai = 0; ai < 2; ai++)
          runPoll(n, k[0], (ai == 0) ? 7'h50 : 7'h2B);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule